// File: doc/BRIEF.md
# Calendar Real-Time Clock with Packed Counter Words

This block keeps wall-clock time and a calendar date. It counts seconds, minutes, hours, day of month, month, year within the century, and century. A prescaler divides the system clock into a one-cycle seconds pulse. The calendar advances on that pulse only while counting is enabled. Month lengths and the Gregorian leap-year rule are handled in hardware.

Software sees five 32-bit registers on a simple select/write bus:

- a time-of-day word;
- a date word;
- an alarm word;
- a control word;
- an alarm status word.

Each counter word has a stored copy. While counting is enabled, a read returns the live time and refreshes that copy. While it is disabled, a read returns the copy. The calendar can be loaded only while the unlock bit is set. Counting resumes from the loaded value.

Top module: `cal_rtc`

## Requirements
- R1: After reset, the control and alarm status registers read 0. With counting disabled, the time word reads 0x0100_0000 (day 1, 00:00:00) and the date word reads 0x0014_0001 (century 20, year 0, month 1).
- R2: Register decode:
  - Word index bits [4:2] select a register only when bits [1:0] are zero and all address bits above bit 4 are zero.
  - Byte offsets: time 0x00, date 0x04, alarm 0x08, control 0x10, status 0x14.
  - Offsets 0x0C, 0x18 and 0x1C, any misaligned address, and any address at or above 0x20 read as zero.
- R3: Time word layout: seconds in [5:0], minutes in [13:8], hours in [20:16], day of month in [28:24]. Every other bit reads zero.
- R4: Date word layout: month (1 to 12) in [3:0], year within the century in [14:8], century in [20:16]. Every other bit reads zero. The full year is century*100 + year.
- R5: A write to a counter word loads the calendar and its stored copy only when control bit 1 (unlock) is set. Otherwise the write has no effect.
- R6: Read behaviour depends on control bit 0 (enable):
  - Enable set: a counter-word read returns the live calendar, and the stored copy takes that value.
  - Enable clear: a read returns the stored copy.
- R7: Counting is driven by the prescaler:
  - While enable is set, the calendar advances one second every TICK_DIV clock cycles. The first advance happens TICK_DIV cycles after enable is set.
  - While enable is clear, the calendar and prescaler hold at rest.
  - A counter load in the same cycle as a tick takes priority, and that tick is dropped.
- R8: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry.
- R9: The day wraps to 1 after the last day of the month. Lengths: 30 days for months 4, 6, 9 and 11; 28 days for February in a common year and 29 in a leap year; 31 days otherwise.
- R10: Month wraps from 12 to 1 and increments the year. Year wraps from 99 to 0 and increments the century.
- R11: A year is a leap year when the full year is divisible by 4, except century years not divisible by 400.
- R12: The alarm and alarm status registers store and return all 32 written bits. The control register keeps only bits [1:0]; its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |

## Verification
The bench sets TICK_DIV to 4, so one second takes four clock cycles. This makes every rollover reachable within a few cycles of loading a value.

A sweep covers every month of the years 1999, 2000, 2023, 2024, 2099 and 2100. For each, the calendar is loaded at the last second of the second-to-last day and of the last day. The bench then checks the result of one tick against a Gregorian month-length model computed in the bench. This sweep exercises:
- the common and leap February;
- a century that is a leap year and one that is not;
- the year-99 to century carry.

Separate sequences cover the prescaler phase, gating by enable and unlock, field masking, and decode.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

    localparam int SEC_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YR_W   = 7;
    localparam int CENT_W = 5;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [CENT_W-1:0] cent;
        logic [YR_W-1:0]   yr;
        logic [MON_W-1:0]  mon;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [SEC_W-1:0]  mins;
        logic [SEC_W-1:0]  secs;
    } cal_t;

    typedef struct packed {
        logic [1:0]        ctrl;
        logic [WORD_W-1:0] alarm;
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] tcopy;
        logic [WORD_W-1:0] dcopy;
    } regs_t;

    // Leap test without a multiply: century*100 is always a multiple of 4.
    function automatic logic is_leap(logic [CENT_W-1:0] cent, logic [YR_W-1:0] yr);
        if (yr == '0) return (cent[1:0] == 2'b00);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [DAY_W-1:0] month_len(logic [MON_W-1:0] mon, logic leap);
        case (mon)
            4'd2:                    return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_time(cal_t c);
        return {3'b0, c.day, 3'b0, c.hour, 2'b0, c.mins, 2'b0, c.secs};
    endfunction

    function automatic logic [WORD_W-1:0] pack_date(cal_t c);
        return {11'b0, c.cent, 1'b0, c.yr, 4'b0, c.mon};
    endfunction

    function automatic cal_t unpack_words(logic [WORD_W-1:0] tw, logic [WORD_W-1:0] dw);
        cal_t c;
        c.secs = tw[5:0];
        c.mins = tw[13:8];
        c.hour = tw[20:16];
        c.day  = tw[28:24];
        c.mon  = dw[3:0];
        c.yr   = dw[14:8];
        c.cent = dw[20:16];
        return c;
    endfunction

endpackage

// File: rtl/cal_rtc_prescale.sv
module cal_rtc_prescale #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/cal_rtc_calendar.sv
module cal_rtc_calendar
    import cal_rtc_pkg::*;
#(
    parameter int RST_CENT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load_time,
    input  logic load_date,
    input  cal_t ld_val,
    output cal_t cal_o
);
    localparam cal_t RST_CAL = '{cent: CENT_W'(RST_CENT), yr: '0, mon: 4'd1,
                                 day: 5'd1, hour: '0, mins: '0, secs: '0};

    cal_t cal_d, cal_q;
    logic leap;
    logic [DAY_W-1:0] mlen;

    always_comb begin
        leap  = is_leap(cal_q.cent, cal_q.yr);
        mlen  = month_len(cal_q.mon, leap);
        cal_d = cal_q;
        if (load_time || load_date) begin
            if (load_time) begin
                cal_d.secs = ld_val.secs;
                cal_d.mins = ld_val.mins;
                cal_d.hour = ld_val.hour;
                cal_d.day  = ld_val.day;
            end
            if (load_date) begin
                cal_d.mon  = ld_val.mon;
                cal_d.yr   = ld_val.yr;
                cal_d.cent = ld_val.cent;
            end
        end else if (tick) begin
            if (cal_q.secs < 6'd59) cal_d.secs = cal_q.secs + 1'b1;
            else begin
                cal_d.secs = '0;
                if (cal_q.mins < 6'd59) cal_d.mins = cal_q.mins + 1'b1;
                else begin
                    cal_d.mins = '0;
                    if (cal_q.hour < 5'd23) cal_d.hour = cal_q.hour + 1'b1;
                    else begin
                        cal_d.hour = '0;
                        if (cal_q.day < mlen) cal_d.day = cal_q.day + 1'b1;
                        else begin
                            cal_d.day = 5'd1;
                            if (cal_q.mon < 4'd12) cal_d.mon = cal_q.mon + 1'b1;
                            else begin
                                cal_d.mon = 4'd1;
                                if (cal_q.yr < 7'd99) cal_d.yr = cal_q.yr + 1'b1;
                                else begin
                                    cal_d.yr   = '0;
                                    cal_d.cent = cal_q.cent + 1'b1;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= RST_CAL;
        else        cal_q <= cal_d;
    end

    assign cal_o = cal_q;

    // R8
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_time && !load_date && cal_q.secs == 6'd59) |=> (cal_q.secs == '0));

    // R7
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_time && !load_date) |=> $stable(cal_q));

    // R10
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_time && !load_date && cal_q.secs == 6'd59 && cal_q.mins == 6'd59 &&
         cal_q.hour == 5'd23 && cal_q.day >= mlen && cal_q.mon == 4'd12 && cal_q.yr == 7'd99)
        |=> (cal_q.yr == '0 && cal_q.cent == $past(cal_q.cent) + 1'b1));

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000,
    parameter int ADDR_W   = 8,
    parameter int RST_CENT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [2:0] IDX_TIME  = 3'd0;
    localparam logic [2:0] IDX_DATE  = 3'd1;
    localparam logic [2:0] IDX_ALARM = 3'd2;
    localparam logic [2:0] IDX_CTRL  = 3'd4;
    localparam logic [2:0] IDX_STAT  = 3'd5;
    localparam int EN_BIT  = 0;
    localparam int UNL_BIT = 1;
    localparam logic [31:0] RST_TIME = 32'h0100_0000;
    localparam logic [31:0] RST_DATE = {11'b0, CENT_W'(RST_CENT), 8'b0, 8'h01};
    localparam regs_t REG_RST = '{ctrl: '0, alarm: '0, status: '0,
                                  tcopy: RST_TIME, dcopy: RST_DATE};

    regs_t regs_d, regs_q;
    cal_t  cal, ld_val;
    logic  in_range, mapped, wr_acc, rd_acc, en, unl;
    logic  load_time, load_date, tick;
    logic [2:0]  idx;
    logic [31:0] live_time, live_date;

    always_comb begin
        in_range  = ((bus_addr >> 5) == '0) && (bus_addr[1:0] == 2'b00);
        idx       = bus_addr[4:2];
        mapped    = in_range && (idx == IDX_TIME || idx == IDX_DATE || idx == IDX_ALARM ||
                                 idx == IDX_CTRL || idx == IDX_STAT);
        wr_acc    = bus_sel && bus_wr && mapped;
        rd_acc    = bus_sel && !bus_wr && mapped;
        en        = regs_q.ctrl[EN_BIT];
        unl       = regs_q.ctrl[UNL_BIT];
        load_time = wr_acc && unl && (idx == IDX_TIME);
        load_date = wr_acc && unl && (idx == IDX_DATE);
        ld_val    = unpack_words(bus_wdata, bus_wdata);
        live_time = pack_time(cal);
        live_date = pack_date(cal);
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (idx)
                IDX_TIME:  bus_rdata = en ? live_time : regs_q.tcopy;
                IDX_DATE:  bus_rdata = en ? live_date : regs_q.dcopy;
                IDX_ALARM: bus_rdata = regs_q.alarm;
                IDX_CTRL:  bus_rdata = {30'b0, regs_q.ctrl};
                IDX_STAT:  bus_rdata = regs_q.status;
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_acc) begin
            case (idx)
                IDX_ALARM: regs_d.alarm  = bus_wdata;
                IDX_CTRL:  regs_d.ctrl   = bus_wdata[1:0];
                IDX_STAT:  regs_d.status = bus_wdata;
                default:   ;
            endcase
        end
        if (load_time) regs_d.tcopy = pack_time(ld_val);
        if (load_date) regs_d.dcopy = pack_date(ld_val);
        if (rd_acc && en && idx == IDX_TIME) regs_d.tcopy = live_time;
        if (rd_acc && en && idx == IDX_DATE) regs_d.dcopy = live_date;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REG_RST;
        else        regs_q <= regs_d;
    end

    cal_rtc_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .tick (tick)
    );

    cal_rtc_calendar #(.RST_CENT(RST_CENT)) u_calendar (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_time(load_time),
        .load_date(load_date),
        .ld_val   (ld_val),
        .cal_o    (cal)
    );

    // R5
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && in_range && idx == IDX_TIME && !unl) |=> $stable(regs_q.tcopy));

    // R6
    live_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && en && idx == IDX_DATE) |=> (regs_q.dcopy == $past(bus_rdata)));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !mapped) |-> (bus_rdata == '0));

    // R12
    ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && mapped && idx == IDX_CTRL) |-> (bus_rdata[31:2] == '0));

endmodule

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb;
    localparam int DIV = 4;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cal_rtc #(.TICK_DIV(DIV), .ADDR_W(AW), .RST_CENT(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    function automatic int is_leap_y(int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int mdays(int m, int y);
        if (m == 2) return is_leap_y(y) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] tword(int d, int h, int mi, int s);
        return 32'(d * 16777216 + h * 65536 + mi * 256 + s);
    endfunction

    function automatic logic [31:0] dword(int y, int m);
        return 32'((y / 100) * 65536 + (y % 100) * 256 + m);
    endfunction

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int ys[6] = '{1999, 2000, 2023, 2024, 2099, 2100};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk("R1 time", v, 32'h0100_0000);
        rd(8'h04, v); chk("R1 date", v, 32'h0014_0001);
        rd(8'h10, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h14, v); chk("R1 status", v, 32'h0);

        // R5 locked writes ignored
        wr(8'h00, 32'h0102_0304);
        wr(8'h04, 32'h0013_0505);
        rd(8'h00, v); chk("R5 locked time", v, 32'h0100_0000);
        rd(8'h04, v); chk("R5 locked date", v, 32'h0014_0001);
        wr(8'h10, 32'h1);
        rd(8'h00, v); chk("R5 live time", v, 32'h0100_0000);
        wr(8'h10, 32'h0);

        // R12 storage registers
        wr(8'h08, 32'hA5A5_1234);
        rd(8'h08, v); chk("R12 alarm", v, 32'hA5A5_1234);
        wr(8'h14, 32'h0000_0003);
        rd(8'h14, v); chk("R12 status", v, 32'h0000_0003);
        wr(8'h10, 32'hFFFF_FFFC);
        rd(8'h10, v); chk("R12 ctrl mask", v, 32'h0);

        // R2 unmapped and misaligned
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R2 0x0C", v, 32'h0);
        rd(8'h18, v); chk("R2 0x18", v, 32'h0);
        rd(8'h1C, v); chk("R2 0x1C", v, 32'h0);
        rd(8'h28, v); chk("R2 0x28", v, 32'h0);
        rd(8'h09, v); chk("R2 misaligned", v, 32'h0);
        rd(8'h08, v); chk("R2 alarm intact", v, 32'hA5A5_1234);

        // R3 R4 field masking on load
        wr(8'h10, 32'h2);
        rd(8'h10, v); chk("R12 ctrl unlock", v, 32'h2);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R3 time mask", v, 32'h1F1F_3F3F);
        rd(8'h04, v); chk("R4 date mask", v, 32'h001F_7F0F);

        // R7 halt while disabled, then tick phase
        wr(8'h00, tword(3, 5, 6, 7));
        wr(8'h04, dword(2024, 3));
        repeat (20) @(negedge clk);
        wr(8'h10, 32'h3);
        rd(8'h00, v); chk("R7 halted", v, tword(3, 5, 6, 7));
        repeat (DIV - 2) @(negedge clk);
        rd(8'h00, v); chk("R7 before tick", v, tword(3, 5, 6, 7));
        rd(8'h00, v); chk("R7 first tick", v, tword(3, 5, 6, 8));
        repeat (DIV - 1) @(negedge clk);
        rd(8'h00, v); chk("R7 second tick", v, tword(3, 5, 6, 9));
        wr(8'h10, 32'h2);

        // R8 minute carry without hour wrap
        wr(8'h00, tword(3, 10, 59, 59));
        wr(8'h10, 32'h3);
        repeat (DIV) @(negedge clk);
        rd(8'h00, v); chk("R8 minute carry", v, tword(3, 11, 0, 0));
        wr(8'h10, 32'h2);

        // R9 R10 R11 sweep over months and years
        foreach (ys[i]) begin
            for (int m = 1; m <= 12; m++) begin
                for (int last = 0; last <= 1; last++) begin
                    int y, dl, d0, ed, em, ey;
                    y  = ys[i];
                    dl = mdays(m, y);
                    d0 = last ? dl : dl - 1;
                    ed = last ? 1 : dl;
                    em = last ? ((m == 12) ? 1 : m + 1) : m;
                    ey = (last && m == 12) ? y + 1 : y;
                    wr(8'h00, tword(d0, 23, 59, 59));
                    wr(8'h04, dword(y, m));
                    wr(8'h10, 32'h3);
                    repeat (DIV) @(negedge clk);
                    rd(8'h00, v);
                    chk(last ? "R9 day wrap" : "R11 day in range", v, tword(ed, 0, 0, 0));
                    rd(8'h04, v);
                    chk((m == 12 && last) ? "R10 year carry" : "R4 date after tick", v, dword(ey, em));
                    wr(8'h10, 32'h2);
                    rd(8'h00, v);
                    chk("R6 stored copy", v, tword(ed, 0, 0, 0));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule